// File: doc/BRIEF.md
# Framebuffer Line-Fetch Engine

This block streams display pixel data out of memory into a local word FIFO, one scan line at a time. A frame is described by a start byte address, a visible line length in 32-bit words, a total frame size in words and a byte skip. The skip is added to the read address after the last word of every visible line, so the visible window can sit inside a wider virtual framebuffer. A 5-bit sub-word pixel offset travels with the frame for the serializer downstream.

Reads go out as bursts on a simple request/response interface. A request carries the byte address of the first word and the beat count minus one. A burst is normally `BURST` words long, but it is cut short where a line or the frame ends. A new burst is issued only when the FIFO level leaves room for two more bursts and a margin. The base, skip and offset values are shadowed: an update strobe marks them pending, and they are loaded only at the next frame start. FIFO underflow, FIFO overwrite and memory error events are held in sticky status bits, and an interrupt is raised for each unmasked bit. The reset input is asynchronous, active low, and is expected to be released synchronously to `clk`.

Top module: `fb_line_fetch`

## Requirements
- R1: After reset, `mem_req_valid`, `busy`, `irq`, `irq_status`, `update_pending` and `px_level` are 0, and `px_empty` is 1.
- R2: A request presents the byte address of its first word on `mem_req_addr` and its beat count minus one on `mem_req_len`. It stays unchanged until `mem_req_ready` is seen. A burst holds `BURST` words unless it is shortened so that it ends exactly at the end of a line or the end of the frame.
- R3: Within a line, words are read from consecutive addresses that step by 4. The word after the last word of a line is read from that last address plus 4 plus the active skip in bytes. Once `cfg_frame_words` words have been requested, the next frame starts again at the active base address.
- R4: A change on `cfg_base`, `cfg_skip` or `cfg_pixoff` has no effect until `cfg_update` is pulsed. After the pulse, `update_pending` is 1 until the next frame start. At that frame start the new values are applied and `update_pending` drops.
- R5: A new burst is requested only when `px_level` is at or below `DEPTH - (2*BURST + 3)`.
- R6: `busy` is 1 from the cycle after a burst is decided until its last beat is received. When `enable` is cleared, the burst in flight completes and no further request is made.
- R7: Response beats enter the FIFO and leave on `px_data` in the order they arrived. A pop takes place on a clock edge where `px_pop` is high and the FIFO is not empty.
- R8: `irq_status` bit 0 is set by a pop while the FIFO is empty. Bit 1 is set by a response beat that arrives while the FIFO is full, and that beat is dropped. Bit 2 is set by a beat with `mem_rsp_err` high. The bits are sticky and are cleared by a one in the matching `irq_clear` bit. A new event in the same cycle wins over the clear.
- R9: `irq` is the OR over all bits of `irq_status & irq_enable`.
- R10: `pix_offset` shows the active 5-bit pixel offset. It changes only under the frame-start rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames and bursts |
| cfg_base | input | ADDR_W | Frame start byte address (shadowed) |
| cfg_skip | input | SKIP_W | Bytes added after each line (shadowed) |
| cfg_pixoff | input | 5 | Start bit within the first word (shadowed) |
| cfg_line_words | input | LINE_W | Visible words per line |
| cfg_frame_words | input | FRAME_W | Words per frame |
| cfg_update | input | 1 | Marks shadow values for loading at next frame start |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | First word byte address |
| mem_req_len | output | LEN_W | Beats minus one |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | 32 | Response word |
| mem_rsp_err | input | 1 | Response beat has an error |
| px_pop | input | 1 | Pixel side takes one word |
| px_data | output | 32 | Oldest FIFO word |
| px_empty | output | 1 | FIFO empty |
| px_level | output | LVL_W | FIFO fill level in words |
| pix_offset | output | 5 | Active pixel offset |
| update_pending | output | 1 | Shadow update waiting for frame start |
| busy | output | 1 | Burst in flight |
| irq_enable | input | 3 | Interrupt mask per status bit |
| irq_clear | input | 3 | Write-one-to-clear per status bit |
| irq_status | output | 3 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
A wrong line or frame counter shows up at once as a wrong `mem_req_addr` or `mem_req_len`, either on the burst that crosses a line end or on the first burst of the next frame. The bench therefore compares every request against an address model built from the requirements. A fault in the FIFO pointers appears on `px_data` within one pop, because each word carries its own address. A shadow register that loads at the wrong time gives the old or the new base one frame away from where it should appear. The threshold gate is judged by the final `px_level` when nothing pops.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_DATA = 2'd2
  } fetch_state_e;

  localparam int unsigned EV_UNDERFLOW = 0;
  localparam int unsigned EV_OVERWRITE = 1;
  localparam int unsigned EV_MEMERR    = 2;
  localparam int unsigned EV_COUNT     = 3;
  localparam int unsigned OFF_W        = 5;
endpackage

// File: rtl/lfd_fifo.sv
module lfd_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ovf_evt,
  output logic             udf_evt
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [LVL_W-1:0] level_n;
  logic             do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = wr_en & ~full;
  assign do_pop  = rd_en & ~empty;
  assign ovf_evt = wr_en & full;
  assign udf_evt = rd_en & empty;
  assign rd_data = store[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    level_n  = level;
    if (do_push) wr_ptr_n = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_n = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    case ({do_push, do_pop})
      2'b10:   level_n = level + 1'b1;
      2'b01:   level_n = level - 1'b1;
      default: level_n = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= wr_data;
  end

  AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)) else $error("fifo level above depth"); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !rd_en |=> full) else $error("dropped beat changed full"); // R8
endmodule

// File: rtl/lfd_irq.sv
module lfd_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] status_n;

  always_comb status_n = (status & ~clr) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_n;
  end

  assign irq = |(status & en);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      status[i] && !clr[i] |=> status[i]) else $error("status bit lost"); // R8
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> status[i]) else $error("event not recorded"); // R8
  end
endmodule

// File: rtl/lfd_addr_gen.sv
module lfd_addr_gen #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned SKIP_W  = 16,
  parameter int unsigned OFF_W   = 5,
  parameter int unsigned BURST   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [SKIP_W-1:0]  cfg_skip,
  input  logic [OFF_W-1:0]   cfg_pixoff,
  input  logic [LINE_W-1:0]  cfg_line_words,
  input  logic [FRAME_W-1:0] cfg_frame_words,
  input  logic               cfg_update,
  input  logic               frame_start,
  input  logic               issue,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [FRAME_W-1:0] burst_words,
  output logic               frame_done,
  output logic [OFF_W-1:0]   pix_offset,
  output logic               update_pending
);
  logic [ADDR_W-1:0]  act_base, act_base_n, cur_addr_n;
  logic [SKIP_W-1:0]  act_skip, act_skip_n;
  logic [OFF_W-1:0]   act_off, act_off_n;
  logic [LINE_W-1:0]  act_line, act_line_n, line_left, line_left_n;
  logic [FRAME_W-1:0] frame_left, frame_left_n, line_lim;
  logic               pending_n, apply;
  logic [ADDR_W-1:0]  step;

  assign frame_done     = (frame_left == '0);
  assign pix_offset     = act_off;
  assign apply          = update_pending | cfg_update;
  assign line_lim       = FRAME_W'(line_left);
  assign step           = ADDR_W'(burst_words) << 2;

  always_comb begin
    burst_words = FRAME_W'(BURST);
    if (line_lim < burst_words)   burst_words = line_lim;
    if (frame_left < burst_words) burst_words = frame_left;
  end

  always_comb begin
    act_base_n   = act_base;
    act_skip_n   = act_skip;
    act_off_n    = act_off;
    act_line_n   = act_line;
    cur_addr_n   = cur_addr;
    line_left_n  = line_left;
    frame_left_n = frame_left;
    pending_n    = update_pending | cfg_update;
    if (frame_start) begin
      if (apply) begin
        act_base_n = cfg_base;
        act_skip_n = cfg_skip;
        act_off_n  = cfg_pixoff;
      end
      cur_addr_n   = apply ? cfg_base : act_base;
      act_line_n   = cfg_line_words;
      line_left_n  = cfg_line_words;
      frame_left_n = cfg_frame_words;
      pending_n    = 1'b0;
    end else if (issue) begin
      frame_left_n = frame_left - burst_words;
      if (line_lim == burst_words) begin
        cur_addr_n  = cur_addr + step + ADDR_W'(act_skip);
        line_left_n = act_line;
      end else begin
        cur_addr_n  = cur_addr + step;
        line_left_n = line_left - LINE_W'(burst_words);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_base       <= '0;
      act_skip       <= '0;
      act_off        <= '0;
      act_line       <= '0;
      cur_addr       <= '0;
      line_left      <= '0;
      frame_left     <= '0;
      update_pending <= 1'b0;
    end else begin
      act_base       <= act_base_n;
      act_skip       <= act_skip_n;
      act_off        <= act_off_n;
      act_line       <= act_line_n;
      cur_addr       <= cur_addr_n;
      line_left      <= line_left_n;
      frame_left     <= frame_left_n;
      update_pending <= pending_n;
    end
  end

  AST_APPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !update_pending) else $error("pending not cleared"); // R4
  AST_OFFSET_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(pix_offset)) else $error("offset moved mid-frame"); // R10
  AST_ISSUE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !frame_done) else $error("burst past frame end"); // R3
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINE_W  = 16,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned SKIP_W  = 16,
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned BURST   = 8,
  localparam int unsigned LEN_W  = (BURST > 1) ? $clog2(BURST) : 1,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [SKIP_W-1:0]  cfg_skip,
  input  logic [4:0]         cfg_pixoff,
  input  logic [LINE_W-1:0]  cfg_line_words,
  input  logic [FRAME_W-1:0] cfg_frame_words,
  input  logic               cfg_update,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [LEN_W-1:0]   mem_req_len,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  input  logic               mem_rsp_err,
  input  logic               px_pop,
  output logic [31:0]        px_data,
  output logic               px_empty,
  output logic [LVL_W-1:0]   px_level,
  output logic [4:0]         pix_offset,
  output logic               update_pending,
  output logic               busy,
  input  logic [2:0]         irq_enable,
  input  logic [2:0]         irq_clear,
  output logic [2:0]         irq_status,
  output logic               irq
);
  import lfd_pkg::*;

  localparam int unsigned THRESH = DEPTH - (2 * BURST + 3);

  fetch_state_e       state, state_n;
  logic [LEN_W-1:0]   beats_left, beats_left_n, req_len_n;
  logic [ADDR_W-1:0]  req_addr_n;
  logic               frame_start, issue, room;
  logic [ADDR_W-1:0]  cur_addr;
  logic [FRAME_W-1:0] burst_words;
  logic               frame_done;
  logic               fifo_full, ovf_evt, udf_evt;
  logic [EV_COUNT-1:0] events;

  lfd_addr_gen #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W),
    .SKIP_W(SKIP_W), .OFF_W(OFF_W), .BURST(BURST)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .cfg_base(cfg_base), .cfg_skip(cfg_skip), .cfg_pixoff(cfg_pixoff),
    .cfg_line_words(cfg_line_words), .cfg_frame_words(cfg_frame_words),
    .cfg_update(cfg_update), .frame_start(frame_start), .issue(issue),
    .cur_addr(cur_addr), .burst_words(burst_words), .frame_done(frame_done),
    .pix_offset(pix_offset), .update_pending(update_pending)
  );

  lfd_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mem_rsp_valid), .wr_data(mem_rsp_data),
    .rd_en(px_pop), .rd_data(px_data),
    .level(px_level), .full(fifo_full), .empty(px_empty),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt)
  );

  always_comb begin
    events               = '0;
    events[EV_UNDERFLOW] = udf_evt;
    events[EV_OVERWRITE] = ovf_evt;
    events[EV_MEMERR]    = mem_rsp_valid & mem_rsp_err;
  end

  lfd_irq #(.N(EV_COUNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(events), .clr(irq_clear),
    .en(irq_enable), .status(irq_status), .irq(irq)
  );

  assign room          = (px_level <= LVL_W'(THRESH));
  assign busy          = (state != FS_IDLE);
  assign mem_req_valid = (state == FS_REQ);

  always_comb begin
    state_n      = state;
    beats_left_n = beats_left;
    req_addr_n   = mem_req_addr;
    req_len_n    = mem_req_len;
    frame_start  = 1'b0;
    issue        = 1'b0;
    case (state)
      FS_IDLE: begin
        if (enable) begin
          if (frame_done) begin
            frame_start = 1'b1;
          end else if (room) begin
            issue      = 1'b1;
            req_addr_n = cur_addr;
            req_len_n  = LEN_W'(burst_words - FRAME_W'(1));
            state_n    = FS_REQ;
          end
        end
      end
      FS_REQ: begin
        if (mem_req_ready) begin
          beats_left_n = mem_req_len;
          state_n      = FS_DATA;
        end
      end
      FS_DATA: begin
        if (mem_rsp_valid) begin
          if (beats_left == '0) state_n = FS_IDLE;
          else                  beats_left_n = beats_left - 1'b1;
        end
      end
      default: state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= FS_IDLE;
      beats_left   <= '0;
      mem_req_addr <= '0;
      mem_req_len  <= '0;
    end else begin
      state        <= state_n;
      beats_left   <= beats_left_n;
      mem_req_addr <= req_addr_n;
      mem_req_len  <= req_len_n;
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_len)) else $error("request changed while waiting"); // R2
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(px_level) <= LVL_W'(THRESH))
    else $error("burst above threshold"); // R5
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(enable)) else $error("burst while disabled"); // R6
  AST_DATA_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req_valid |-> $past(busy)) else $error("data phase without request"); // R6
endmodule

// File: tb/fb_line_fetch_tb.sv
module fb_line_fetch_tb;
  localparam int unsigned DEPTH  = 32;
  localparam int unsigned BURST  = 4;
  localparam int unsigned THRESH = DEPTH - (2 * BURST + 3);

  // {base, line_words, skip_bytes, frame_words, requests_per_frame}
  localparam logic [63:0] CASES [0:3] = '{
    {32'h0000_1000, 8'd8,  8'd0,  8'd16, 8'd4},
    {32'h0000_2000, 8'd6,  8'd8,  8'd18, 8'd6},
    {32'h0000_3000, 8'd3,  8'd20, 8'd9,  8'd3},
    {32'h0000_4000, 8'd10, 8'd4,  8'd7,  8'd2}
  };

  logic        clk, rst_n, enable, cfg_update;
  logic [31:0] cfg_base;
  logic [15:0] cfg_skip;
  logic [4:0]  cfg_pixoff;
  logic [15:0] cfg_line_words;
  logic [23:0] cfg_frame_words;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_len;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        px_pop, pop_auto, pop_force, pop_on;
  logic [31:0] px_data;
  logic        px_empty;
  logic [5:0]  px_level;
  logic [4:0]  pix_offset;
  logic        update_pending, busy, irq;
  logic [2:0]  irq_enable, irq_clear, irq_status;

  int checks, errors, log_n, pop_idx, n_wexp, exp_cnt;
  logic [31:0] log_addr [0:63];
  int          log_len  [0:63];
  logic [31:0] exp_addr [0:63];
  int          exp_len  [0:63];
  logic [31:0] exp_word [0:255];
  logic [31:0] err_addr, mm_addr;
  int          mm_n;

  fb_line_fetch #(.DEPTH(DEPTH), .BURST(BURST)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_base(cfg_base), .cfg_skip(cfg_skip), .cfg_pixoff(cfg_pixoff),
    .cfg_line_words(cfg_line_words), .cfg_frame_words(cfg_frame_words),
    .cfg_update(cfg_update),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .px_pop(px_pop), .px_data(px_data), .px_empty(px_empty), .px_level(px_level),
    .pix_offset(pix_offset), .update_pending(update_pending), .busy(busy),
    .irq_enable(irq_enable), .irq_clear(irq_clear), .irq_status(irq_status), .irq(irq)
  );

  assign px_pop = pop_auto | pop_force;
  assign mem_req_ready = 1'b1;

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: data word equals its own byte address
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    mem_rsp_err   = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        mm_addr = mem_req_addr;
        mm_n    = int'(mem_req_len) + 1;
        if (log_n < 64) begin
          log_addr[log_n] = mm_addr;
          log_len[log_n]  = mm_n;
        end
        log_n++;
        for (int k = 0; k < mm_n; k++) begin
          @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mm_addr + 32'(4 * k);
          mem_rsp_err   = ((mm_addr + 32'(4 * k)) == err_addr);
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
      end
    end
  end

  // pixel side: pops whenever data is present, checks order (R7)
  initial begin
    pop_auto = 1'b0;
    forever begin
      @(negedge clk);
      pop_auto = pop_on && !px_empty;
      if (pop_auto) begin
        if (pop_idx < n_wexp) chk("R7 pop order", px_data, exp_word[pop_idx]);
        pop_idx++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    log_n   = 0;
    pop_idx = 0;
    n_wexp  = 0;
    rst_n   = 1'b1;
  endtask

  task automatic pulse_update();
    @(negedge clk);
    cfg_update = 1'b1;
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int t = 0; t < 3000 && log_n < n; t++) @(negedge clk);
  endtask

  // request model from R2/R3: one frame, then the first burst of the next
  task automatic build_model(input logic [31:0] base, input int line_w,
                             input int skip, input int frame_w);
    logic [31:0] a;
    int ll, left, len, nw;
    a = base; ll = line_w; left = frame_w; exp_cnt = 0; nw = 0;
    while (left > 0) begin
      len = BURST;
      if (ll < len) len = ll;
      if (left < len) len = left;
      exp_addr[exp_cnt] = a;
      exp_len[exp_cnt]  = len;
      exp_cnt++;
      a = a + 32'(4 * len); ll -= len; left -= len;
      if (ll == 0) begin a = a + 32'(skip); ll = line_w; end
    end
    len = BURST;
    if (line_w < len) len = line_w;
    if (frame_w < len) len = frame_w;
    exp_addr[exp_cnt] = base;
    exp_len[exp_cnt]  = len;
    exp_cnt++;
    for (int i = 0; i < exp_cnt; i++)
      for (int k = 0; k < exp_len[i]; k++) begin
        exp_word[nw] = exp_addr[i] + 32'(4 * k);
        nw++;
      end
    n_wexp = nw;
  endtask

  initial begin
    checks = 0; errors = 0; log_n = 0; pop_idx = 0; n_wexp = 0;
    rst_n = 1'b0; enable = 1'b0; cfg_update = 1'b0; pop_on = 1'b0; pop_force = 1'b0;
    cfg_base = '0; cfg_skip = '0; cfg_pixoff = '0; cfg_line_words = '0; cfg_frame_words = '0;
    irq_enable = '0; irq_clear = '0; err_addr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_valid", 32'(mem_req_valid), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 empty", 32'(px_empty), 1);
    chk("R1 level", 32'(px_level), 0);
    chk("R1 status", 32'(irq_status), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pending", 32'(update_pending), 0);

    // R8 underflow: pop with empty FIFO sets bit 0
    pop_force = 1'b1;
    @(negedge clk);
    pop_force = 1'b0;
    @(negedge clk);
    chk("R8 underflow bit0", 32'(irq_status), 32'b001);

    // table walk: R2, R3, R7
    for (int c = 0; c < 4; c++) begin
      do_reset();
      cfg_base        = CASES[c][63:32];
      cfg_line_words  = 16'(CASES[c][31:24]);
      cfg_skip        = 16'(CASES[c][23:16]);
      cfg_frame_words = 24'(CASES[c][15:8]);
      build_model(CASES[c][63:32], int'(CASES[c][31:24]), int'(CASES[c][23:16]),
                  int'(CASES[c][15:8]));
      pulse_update();
      pop_on = 1'b1;
      enable = 1'b1;
      wait_log(exp_cnt);
      enable = 1'b0;
      repeat (40) @(negedge clk);
      pop_on = 1'b0;
      for (int i = 0; i < exp_cnt; i++) begin
        chk("R3 request address", log_addr[i], exp_addr[i]);
        chk("R2 request beats", 32'(log_len[i]), 32'(exp_len[i]));
      end
      chk("R3 next frame restarts at base", log_addr[int'(CASES[c][7:0])], CASES[c][63:32]);
      checks++;
      if (pop_idx < n_wexp) begin
        errors++;
        $display("FAIL R7 words popped actual=%0d expected=%0d", pop_idx, n_wexp);
      end
    end

    // R4 / R10 shadowing
    do_reset();
    cfg_base = 32'h1000; cfg_skip = 0; cfg_line_words = 4; cfg_frame_words = 8;
    cfg_pixoff = 5'd3;
    pulse_update();
    pop_on = 1'b1;
    enable = 1'b1;
    wait_log(1);
    chk("R10 offset applied", 32'(pix_offset), 3);
    cfg_base = 32'h5000; cfg_pixoff = 5'd9;
    wait_log(3);
    chk("R4 base unchanged without strobe", log_addr[2], 32'h1000);
    chk("R10 offset unchanged without strobe", 32'(pix_offset), 3);
    pulse_update();
    chk("R4 pending after strobe", 32'(update_pending), 1);
    wait_log(5);
    chk("R4 new base at frame start", log_addr[4], 32'h5000);
    chk("R4 pending cleared", 32'(update_pending), 0);
    chk("R10 new offset", 32'(pix_offset), 9);
    enable = 1'b0;
    repeat (30) @(negedge clk);
    pop_on = 1'b0;

    // R5 threshold gate, then R8 overwrite and R9 masking
    do_reset();
    cfg_base = 32'h8000; cfg_line_words = 64; cfg_frame_words = 64; cfg_skip = 0;
    pulse_update();
    enable = 1'b1;
    repeat (200) @(negedge clk);
    chk("R5 bursts before gate", 32'(log_n), 32'((THRESH / BURST) + 1));
    chk("R5 level at gate", 32'(px_level), 32'(((THRESH / BURST) + 1) * BURST));
    enable = 1'b0;
    repeat (5) @(negedge clk);
    for (int k = 0; k < DEPTH - ((THRESH / BURST) + 1) * BURST; k++) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hA000_0000 + 32'(k);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk("R8 no overwrite until full", 32'(irq_status[1]), 0);
    chk("R8 level full", 32'(px_level), DEPTH);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk("R8 overwrite bit1", 32'(irq_status[1]), 1);
    chk("R8 overwrite beat dropped", 32'(px_level), DEPTH);
    irq_enable = 3'b000;
    @(negedge clk);
    chk("R9 masked irq", 32'(irq), 0);
    irq_enable = 3'b010;
    @(negedge clk);
    chk("R9 unmasked irq", 32'(irq), 1);
    irq_clear = 3'b010;
    @(negedge clk);
    irq_clear = 3'b000;
    @(negedge clk);
    chk("R8 clear bit1", 32'(irq_status[1]), 0);
    chk("R9 irq after clear", 32'(irq), 0);

    // R6 disable during burst
    do_reset();
    irq_enable = 3'b000;
    cfg_base = 32'h1000; cfg_line_words = 8; cfg_frame_words = 64;
    pulse_update();
    pop_on = 1'b1;
    enable = 1'b1;
    for (int t = 0; t < 100 && !mem_req_valid; t++) @(negedge clk);
    enable = 1'b0;
    chk("R6 busy on request", 32'(busy), 1);
    @(negedge clk);
    chk("R6 busy during beats", 32'(busy), 1);
    repeat (10) @(negedge clk);
    chk("R6 busy low after burst", 32'(busy), 0);
    chk("R6 no further request", 32'(log_n), 1);
    pop_on = 1'b0;

    // R8 memory error bit2, R9
    do_reset();
    err_addr = 32'h1008;
    cfg_base = 32'h1000; cfg_line_words = 8; cfg_frame_words = 8;
    pulse_update();
    pop_on = 1'b1;
    enable = 1'b1;
    wait_log(1);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 memory error bit2", 32'(irq_status[2]), 1);
    irq_enable = 3'b100;
    @(negedge clk);
    chk("R9 irq on memory error", 32'(irq), 1);
    irq_clear = 3'b100;
    @(negedge clk);
    irq_clear = 3'b000;
    @(negedge clk);
    chk("R8 clear bit2", 32'(irq_status[2]), 0);
    pop_on = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule